// File: doc/BRIEF.md
# JTAG Data-Register Scan Master

This block is the host side of a JTAG link. On a single request it runs one data-register scan of a chosen length against a target TAP controller. It generates TCK by dividing the system clock, drives TMS and TDI, and samples TDO.

The TMS walk is fixed. Starting from Update-IR, Update-DR or Run-Test/Idle, the block steps through Select-DR-Scan and Capture-DR into Shift-DR. It shifts the register least significant bit first, and the final bit goes out together with TMS=1. It then moves through Exit1-DR to Update-DR. Once TCK is back low, the block pulses done and presents the bits it captured from TDO.

A frame option builds a 73-bit debug word for targets that reject data without a valid checksum. The word holds a 65-bit payload with a CRC-8 over that payload appended above it.

Top module: `jtag_dr_scanner`

## Requirements
- R1: After reset, busy, done, tck, tms and tdi are 0 and data_out is all zeros. tck is 0 whenever busy is 0.
- R2: A start pulse is accepted only while busy is 0, and only when frame is 1 or length is between 1 and MAX_LEN inclusive. A start while busy, or with length 0 or above MAX_LEN and frame 0, leaves busy low and tck quiet, or leaves the running scan unchanged.
- R3: For an N-bit scan, TMS at the N+4 rising TCK edges reads 1, 0, 0, then N-1 zeros, then 1, 1. This is the walk Select-DR-Scan, Capture-DR, Shift-DR (N cycles), Exit1-DR, Update-DR.
- R4: TDI carries the word latched at start, least significant bit first. Bit k is present at the k-th rising edge in Shift-DR. Inputs that change after the start cycle have no effect.
- R5: TCK toggles every HALF_DIV system clocks while busy. It starts low, and the first rise comes HALF_DIV cycles after the start is accepted. TMS and TDI change only in the cycle where TCK falls, except when a scan is launched or finishes.
- R6: TDO is sampled at each rising TCK edge in Shift-DR, half a TCK period after the target updates it on the falling edge. data_out[k] is the bit sampled in shift cycle k, and data_out bits at N and above read 0.
- R7: busy stays high for exactly 2*(N+4)*HALF_DIV system clocks after the accepting edge. done is high for the single cycle after the last busy cycle, and busy ends only through done.
- R8: With frame=1, length is ignored and N is 73. Bits 0 to 64 are data_in[64:0]. Bits 65 to 72 hold a CRC-8 over those 65 bits, with CRC bit 0 at frame bit 65. The CRC starts at zero and takes data bit 0 first. Each step computes fb = crc[7] ^ bit, shifts the CRC left one place, and XORs CRC_POLY (default 8'h07) in when fb is 1.
- R9: data_out holds its value from done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Scan request, sampled when idle |
| frame | input | 1 | Build the 73-bit payload-plus-CRC word |
| length | input | 8 | Register length in bits when frame is 0 |
| data_in | input | 128 | Word to shift out, bit 0 first |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| data_out | output | 128 | Bits captured from TDO |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to target |
| tdo | input | 1 | JTAG data from target |

## Verification
The bench builds the block with HALF_DIV=2, MAX_LEN=128 and the default polynomial. A half period of two system clocks exercises the divider counter's wrap, so the per-clock reference can tell whether TMS or TDI moves on a system clock other than the one where TCK falls. A MAX_LEN of 128 exceeds the behavioural target's 73-bit register. A full-width scan therefore brings back the bench's own TDI bits after the captured value, which exposes off-by-one sampling. Scans of 1, 8, 73 and 128 bits, together with two framed payloads, cover the shortest walk, the short register and the checksum path.

// File: rtl/jtag_dr_scanner.sv
module jtag_dr_scanner #(
  parameter int          MAX_LEN   = 128,
  parameter int          HALF_DIV  = 2,
  parameter int          FRAME_PAY = 65,
  parameter logic [7:0]  CRC_POLY  = 8'h07,
  localparam int         LEN_W     = $clog2(MAX_LEN + 1),
  localparam int         POS_W     = $clog2(MAX_LEN + 5),
  localparam int         IDX_W     = $clog2(MAX_LEN),
  localparam int         DIV_W     = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1,
  localparam int         FRAME_LEN = FRAME_PAY + 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               frame,
  input  logic [LEN_W-1:0]   length,
  input  logic [MAX_LEN-1:0] data_in,
  output logic               busy,
  output logic               done,
  output logic [MAX_LEN-1:0] data_out,
  output logic               tck,
  output logic               tms,
  output logic               tdi,
  input  logic               tdo
);

  function automatic logic [7:0] crc8(input logic [FRAME_PAY-1:0] d);
    logic [7:0] c;
    logic       fb;
    c = '0;
    for (int i = 0; i < FRAME_PAY; i++) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    end
    return c;
  endfunction

  logic [MAX_LEN-1:0] frame_word, shreg;
  logic [LEN_W-1:0]   len_q, req_len;
  logic [POS_W-1:0]   pos, nxt, last_shift, update_pos;
  logic [DIV_W-1:0]   cnt;
  logic [IDX_W-1:0]   cidx;
  logic               len_ok, in_shift, shift_next, tms_next, wrap;

  always_comb begin
    frame_word = '0;
    frame_word[FRAME_PAY-1:0] = data_in[FRAME_PAY-1:0];
    frame_word[FRAME_PAY +: 8] = crc8(data_in[FRAME_PAY-1:0]);
  end

  assign req_len    = frame ? LEN_W'(FRAME_LEN) : length;
  assign len_ok     = frame || (length != '0 && length <= LEN_W'(MAX_LEN));
  assign last_shift = POS_W'(len_q) + POS_W'(2);
  assign update_pos = POS_W'(len_q) + POS_W'(3);
  assign nxt        = pos + POS_W'(1);
  assign in_shift   = pos >= POS_W'(3) && pos <= last_shift;
  assign shift_next = nxt >= POS_W'(3) && nxt <= last_shift;
  assign tms_next   = (nxt == last_shift) || (nxt == update_pos);
  assign cidx       = IDX_W'(pos - POS_W'(3));
  assign wrap       = cnt == DIV_W'(HALF_DIV - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      tck      <= 1'b0;
      tms      <= 1'b0;
      tdi      <= 1'b0;
      cnt      <= '0;
      pos      <= '0;
      len_q    <= '0;
      shreg    <= '0;
      data_out <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start && len_ok) begin
          busy     <= 1'b1;
          cnt      <= '0;
          pos      <= '0;
          tms      <= 1'b1;
          tdi      <= 1'b0;
          len_q    <= req_len;
          shreg    <= frame ? frame_word : data_in;
          data_out <= '0;
        end
      end else if (wrap) begin
        cnt <= '0;
        tck <= ~tck;
        if (!tck) begin
          if (in_shift) data_out[cidx] <= tdo;
        end else if (pos == update_pos) begin
          busy <= 1'b0;
          done <= 1'b1;
          tms  <= 1'b0;
          tdi  <= 1'b0;
        end else begin
          pos <= nxt;
          tms <= tms_next;
          tdi <= shift_next ? shreg[0] : 1'b0;
          if (shift_next) shreg <= {1'b0, shreg[MAX_LEN-1:1]};
        end
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/jtag_dr_scanner_chk.sv
module jtag_dr_scanner_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic tck,
  input logic tms,
  input logic tdi
);

  p_tck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);

  p_tms_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(tms)) |-> $fell(tck));

  p_tdi_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(tdi)) |-> $fell(tck));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_scan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_busy_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

endmodule

bind jtag_dr_scanner jtag_dr_scanner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .tck(tck), .tms(tms), .tdi(tdi)
);

// File: tb/sim_jtag_dr_scanner.sv
module sim_jtag_dr_scanner;
  localparam int HALF = 2;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         start = 1'b0, frame = 1'b0;
  logic [7:0]   length = '0;
  logic [127:0] data_in = '0;
  logic         busy, done, tck, tms, tdi;
  logic [127:0] data_out;
  logic         tdo = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  jtag_dr_scanner #(.MAX_LEN(128), .HALF_DIV(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .frame(frame), .length(length),
    .data_in(data_in), .busy(busy), .done(done), .data_out(data_out),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  // behavioural target TAP, DR column only
  typedef enum int {RTI, SELDR, CAPDR, SHDR, EX1DR, PAUSEDR, EX2DR, UPDR, SELIR} tap_t;
  tap_t        st = RTI;
  logic [72:0] treg = '0;
  logic [72:0] cap_val = '0;
  bit          tms_q[$];
  bit          tdi_q[$];

  always @(posedge tck) begin
    tms_q.push_back(tms);
    case (st)
      RTI:     st <= tms ? SELDR : RTI;
      SELDR:   st <= tms ? SELIR : CAPDR;
      CAPDR:   begin treg <= cap_val; st <= tms ? EX1DR : SHDR; end
      SHDR:    begin
                 tdi_q.push_back(tdi);
                 treg <= {tdi, treg[72:1]};
                 st <= tms ? EX1DR : SHDR;
               end
      EX1DR:   st <= tms ? UPDR : PAUSEDR;
      PAUSEDR: st <= tms ? EX2DR : PAUSEDR;
      EX2DR:   st <= tms ? UPDR : SHDR;
      UPDR:    st <= tms ? SELDR : RTI;
      default: st <= SELIR;
    endcase
  end

  always @(negedge tck) tdo <= (st == SHDR) ? treg[0] : 1'b0;

  // per-clock reference for tck phase and pin-change timing
  int  kcnt = 0, tck_err = 0, edge_err = 0;
  bit  p_busy = 0, p_tck = 0, p_tms = 0, p_tdi = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        kcnt = kcnt + 1;
        if (tck !== 1'(((kcnt - 1) / HALF) % 2)) tck_err = tck_err + 1;
        if (p_busy && (tms !== p_tms || tdi !== p_tdi) && !(p_tck && !tck))
          edge_err = edge_err + 1;
      end else begin
        kcnt = 0;
        if (tck) tck_err = tck_err + 1;
      end
      p_busy = busy; p_tck = tck; p_tms = tms; p_tdi = tdi;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_ref(input logic [64:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 65; i++) begin
      if (c[7] ^ d[i]) c = {c[6:0], 1'b0} ^ 8'h07;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  task automatic run_scan(input bit fr, input int n_req, input logic [127:0] din,
                          input logic [72:0] capv, input bit poke);
    logic [127:0] sent, expo;
    int n, cyc, tb0, db0, te0, ee0, bad;
    n = fr ? 73 : n_req;
    sent = '0;
    if (fr) begin
      sent[64:0]  = din[64:0];
      sent[72:65] = crc_ref(din[64:0]);
    end else begin
      for (int k = 0; k < n; k++) sent[k] = din[k];
    end
    expo = '0;
    for (int k = 0; k < n; k++) expo[k] = (k < 73) ? capv[k] : sent[k - 73];
    cap_val = capv;
    tb0 = tms_q.size(); db0 = tdi_q.size(); te0 = tck_err; ee0 = edge_err;

    @(negedge clk); start = 1'b1; frame = fr; length = 8'(n_req); data_in = din;
    @(negedge clk); start = 1'b0; length = 8'd3; data_in = ~din; frame = ~fr;
    cyc = 0;
    while (busy && cyc < 5000) begin
      start = (poke && cyc == 20);
      if (poke && cyc == 20) length = 8'd5;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc == 2 * (n + 4) * HALF, "R7 busy length", 128'(cyc), 128'(2 * (n + 4) * HALF));
    chk(done == 1'b1, "R7 done at end", 128'(done), 128'd1);
    chk(data_out == expo, "R6 captured value", data_out, expo);
    if (poke) chk(cyc == 2 * (n + 4) * HALF, "R2 start while busy ignored", 128'(cyc), 128'(2 * (n + 4) * HALF));
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", 128'(done), 128'd0);

    chk(tms_q.size() - tb0 == n + 4, "R3 rising edge count", 128'(tms_q.size() - tb0), 128'(n + 4));
    bad = 0;
    for (int i = 0; i < n + 4 && tb0 + i < tms_q.size(); i++) begin
      bit e;
      e = (i == 0) || (i == n + 2) || (i == n + 3);
      if (tms_q[tb0 + i] != e) bad++;
    end
    chk(bad == 0, "R3 TMS trace", 128'(bad), 128'd0);
    chk(st == UPDR, "R3 target in Update-DR", 128'(st), 128'(UPDR));

    chk(tdi_q.size() - db0 == n, "R4 shift bit count", 128'(tdi_q.size() - db0), 128'(n));
    bad = 0;
    for (int i = 0; i < n && db0 + i < tdi_q.size(); i++)
      if (tdi_q[db0 + i] != sent[i]) bad++;
    chk(bad == 0, "R4 TDI bits LSB first", 128'(bad), 128'd0);
    if (fr) begin
      logic [7:0] got = '0;
      for (int i = 0; i < 8 && db0 + 65 + i < tdi_q.size(); i++) got[i] = tdi_q[db0 + 65 + i];
      chk(got == crc_ref(din[64:0]), "R8 CRC field", 128'(got), 128'(crc_ref(din[64:0])));
    end
    chk(tck_err == te0, "R5 tck phase", 128'(tck_err - te0), 128'd0);
    chk(edge_err == ee0, "R5 pins change on fall", 128'(edge_err - ee0), 128'd0);
  endtask

  task automatic try_bad_len(input logic [7:0] l);
    logic [127:0] held;
    int tb0;
    bit ok;
    held = data_out; tb0 = tms_q.size(); ok = 1;
    @(negedge clk); start = 1'b1; frame = 1'b0; length = l;
    @(negedge clk); start = 1'b0;
    repeat (10) begin
      if (busy || tck) ok = 0;
      @(negedge clk);
    end
    chk(ok && tms_q.size() == tb0, "R2 bad length ignored", 128'(l), 128'd0);
    chk(data_out == held, "R2 data_out untouched", data_out, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 busy/done reset", {busy, done}, 128'd0);
    chk(tck == 0 && tms == 0 && tdi == 0, "R1 pins reset", {tck, tms, tdi}, 128'd0);
    chk(data_out == '0, "R1 data_out reset", data_out, 128'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_scan(1'b1, 5, 128'h1_2345_6789_ABCD_EF01, 73'h062_0000_0000_2000_0000, 1'b0);
    run_scan(1'b0, 8, 128'h0000_00A5, 73'h1_5A5A_5A5A_5A5A_5AC3, 1'b0);
    run_scan(1'b0, 73, {55'h0, 73'h1A5_DEAD_BEEF_CAFE_F00D}, 73'h0F0_1234_5678_9ABC_DEF0, 1'b1);
    run_scan(1'b0, 1, 128'h1, 73'h0, 1'b0);
    run_scan(1'b0, 128, 128'hFEDC_BA98_7654_3210_0123_4567_89AB_CDEF, 73'h155_5555_5555_5555_5555, 1'b0);
    run_scan(1'b1, 73, 128'h0_FFFF_FFFF_FFFF_FFFF, 73'h0AB_0000_1111_2222_3333, 1'b0);

    held = data_out;
    repeat (12) begin @(negedge clk); data_in = data_in + 128'd7; end
    chk(data_out == held, "R9 data_out held", data_out, held);

    try_bad_len(8'd0);
    try_bad_len(8'd200);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule